// File: doc/BRIEF.md
# String Transfer Address Sequencer

This block sequences the addresses of a repeated memory-to-memory string move in a 16-bit, real-mode style datapath. Software first places a source offset, a destination offset, an element count, a direction bit and an element-size bit on the load inputs, then pulses `start`. The block then raises a read request at the source offset and a write request at the destination offset. Each time both requests are accepted in the same cycle, one element has moved. The block then steps both offsets by the element size, up or down, and decrements the remaining count.

Segment translation, data storage and compare-type string operations live in other blocks. The two requests only carry a segment-role code beside each offset. Reads always name the data segment role and writes always name the extra segment role.

The controller has three states. `ST_IDLE` waits for `start`. `ST_MOVE` issues requests until the count reaches zero. `ST_DONE` lasts one cycle and drives `done`. The transitions are as follows:
- IDLE→MOVE happens on `start` with a nonzero count.
- IDLE→DONE happens on `start` with a zero count.
- MOVE→MOVE happens while no handshake occurs or more than one element remains.
- MOVE→DONE happens on the handshake of the final element.
- DONE→IDLE always happens on the next edge.

Top module: `strxfer_seq`

## Requirements
- R1: After reset the block is idle: `rd_valid`, `wr_valid`, `busy` and `done` are 0, and `rd_addr`, `wr_addr` and `remaining` are 0.
- R2: A `start` pulse in idle with `count_init` nonzero loads the offsets and the count. From the next cycle `rd_valid` and `wr_valid` are both 1, `rd_addr`/`wr_addr`/`remaining` show the loaded values, `rd_seg` is 3 (data role) and `wr_seg` is 0 (extra role).
- R3: A transfer completes only in a cycle where the requests are valid and both `rd_ready` and `wr_ready` are 1. In any other cycle the offsets, the count and the valid outputs hold.
- R4: With `dir_down`=0 both offsets increase after each transfer. With `dir_down`=1 both decrease.
- R5: The step is 1 when `elem_word`=0 and 2 when `elem_word`=1. The direction and size are captured at `start`.
- R6: Offset arithmetic wraps modulo 2^16.
- R7: `remaining` decreases by one per transfer. In the cycle after the final transfer, both valids are 0 and `done` is 1 for exactly one cycle. The block then returns to idle.
- R8: A `start` with `count_init`=0 issues no request, and `done` is 1 in the following cycle only.
- R9: `start` is ignored while `busy` is 1 (moving or done). `busy` is 1 in every non-idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (honoured in idle only) |
| dir_down | input | 1 | 1: offsets step downward |
| elem_word | input | 1 | 1: two-byte elements, 0: single bytes |
| src_init | input | 16 | Initial source offset |
| dst_init | input | 16 | Initial destination offset |
| count_init | input | 16 | Number of elements to move |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read port accepts |
| rd_seg | output | 2 | Segment role for the read (3 = data) |
| rd_addr | output | 16 | Current source offset |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write port accepts |
| wr_seg | output | 2 | Segment role for the write (0 = extra) |
| wr_addr | output | 16 | Current destination offset |
| remaining | output | 16 | Elements still to move |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The move is run in four forms, and each separates two behaviours:
- An ascending byte move with both ports always ready confirms the basic step and the count.
- A descending word move under pseudo-random ready patterns separates a true joint handshake from a single-sided one.
- A word move that starts at the top and bottom of the offset range shows that the offsets wrap.
- A zero-count start shows that the block skips straight to completion without issuing a request.

Start pulses with different load values are injected during a move and in its done cycle. These show that an operation in flight cannot be reloaded.

// File: rtl/strxfer_pkg.sv
package strxfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    localparam logic [1:0] SEG_EXTRA = 2'd0;
    localparam logic [1:0] SEG_CODE  = 2'd1;
    localparam logic [1:0] SEG_STACK = 2'd2;
    localparam logic [1:0] SEG_DATA  = 2'd3;

endpackage

// File: rtl/strxfer_ctrl.sv
module strxfer_ctrl
    import strxfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic zero_load,
    input  logic fire,
    input  logic last_elem,
    output logic load,
    output logic req,
    output logic done,
    output logic busy
);

    seq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = zero_load ? ST_DONE : ST_MOVE;
            ST_MOVE: if (fire && last_elem) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load = 1'b0;
        req  = 1'b0;
        done = 1'b0;
        busy = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_MOVE: req  = 1'b1;
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                          // R7
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !fire) |=> req);                                  // R3
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                          // R7

endmodule

// File: rtl/strxfer_ptr.sv
module strxfer_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_val,
    input  logic          adv,
    input  logic          down,
    input  logic          word,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] STEP_B = AW'(1);
    localparam logic [AW-1:0] STEP_W = AW'(2);

    logic [AW-1:0] step;

    always_comb step = word ? STEP_W : STEP_B;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= ld_val;
        else if (adv)  ptr <= down ? (ptr - step) : (ptr + step);
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(ptr));                        // R3
    AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (ptr != $past(ptr)));                  // R4

endmodule

// File: rtl/strxfer_cnt.sv
module strxfer_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] ld_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          last
);

    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= ld_val;
        else if (dec)  cnt <= cnt - ONE;
    end

    always_comb last = (cnt == ONE);

endmodule

// File: rtl/strxfer_seq.sv
module strxfer_seq
    import strxfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_down,
    input  logic          elem_word,
    input  logic [AW-1:0] src_init,
    input  logic [AW-1:0] dst_init,
    input  logic [CW-1:0] count_init,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [1:0]    rd_seg,
    output logic [AW-1:0] rd_addr,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [1:0]    wr_seg,
    output logic [AW-1:0] wr_addr,
    output logic [CW-1:0] remaining,
    output logic          busy,
    output logic          done
);

    logic load, req, fire, last_elem, zero_load;
    logic mode_down, mode_word;

    assign zero_load = (count_init == '0);
    assign fire      = req & rd_ready & wr_ready;

    strxfer_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .zero_load (zero_load),
        .fire      (fire),
        .last_elem (last_elem),
        .load      (load),
        .req       (req),
        .done      (done),
        .busy      (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_down <= 1'b0;
            mode_word <= 1'b0;
        end else if (load) begin
            mode_down <= dir_down;
            mode_word <= elem_word;
        end
    end

    strxfer_ptr #(.AW(AW)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .ld_val (src_init),
        .adv    (fire),
        .down   (mode_down),
        .word   (mode_word),
        .ptr    (rd_addr)
    );

    strxfer_ptr #(.AW(AW)) u_dst (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .ld_val (dst_init),
        .adv    (fire),
        .down   (mode_down),
        .word   (mode_word),
        .ptr    (wr_addr)
    );

    strxfer_cnt #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .ld_val (count_init),
        .dec    (fire),
        .cnt    (remaining),
        .last   (last_elem)
    );

    assign rd_valid = req;
    assign wr_valid = req;
    assign rd_seg   = SEG_DATA;
    assign wr_seg   = SEG_EXTRA;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && wr_ready) |=> (remaining == $past(remaining) - CW'(1))); // R7
    AST_NO_REQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (remaining != '0));                          // R8
    AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !(rd_ready && wr_ready)) |=> $stable(remaining)); // R9

endmodule

// File: tb/strxfer_seq_tb.sv
`timescale 1ns/1ps
module strxfer_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_down = 1'b0, elem_word = 1'b0;
    logic [15:0] src_init = '0, dst_init = '0, count_init = '0;
    logic        rd_ready = 1'b1, wr_ready = 1'b1;
    logic        rd_valid, wr_valid, busy, done;
    logic [1:0]  rd_seg, wr_seg;
    logic [15:0] rd_addr, wr_addr, remaining;

    always #2.5 clk = ~clk;

    strxfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_down(dir_down),
        .elem_word(elem_word), .src_init(src_init), .dst_init(dst_init),
        .count_init(count_init), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_seg(rd_seg), .rd_addr(rd_addr), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_seg(wr_seg), .wr_addr(wr_addr),
        .remaining(remaining), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit run_cmp = 0;
    bit ready_rand = 0;
    string tag = "R4";
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference: 0 idle, 1 moving, 2 done
    int m_state = 0;
    int m_src = 0, m_dst = 0, m_cnt = 0;
    bit m_down = 0, m_word = 0;

    task automatic chk(input string req, input string what,
                       input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_down = 0; m_word = 0;
        end else begin
            case (m_state)
                0: if (start) begin
                    m_src = src_init; m_dst = dst_init; m_cnt = count_init;
                    m_down = dir_down; m_word = elem_word;
                    m_state = (count_init == 0) ? 2 : 1;
                end
                1: if (rd_ready && wr_ready) begin
                    int st;
                    st = m_word ? 2 : 1;
                    m_src = m_down ? (m_src - st) & 16'hFFFF : (m_src + st) & 16'hFFFF;
                    m_dst = m_down ? (m_dst - st) & 16'hFFFF : (m_dst + st) & 16'hFFFF;
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) m_state = 2;
                end
                default: m_state = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (run_cmp) begin
            chk("R3", "rd_valid", rd_valid, m_state == 1);
            chk("R3", "wr_valid", wr_valid, m_state == 1);
            chk("R7", "done", done, m_state == 2);
            chk("R9", "busy", busy, m_state != 0);
            chk(tag, "rd_addr", rd_addr, m_src);
            chk(tag, "wr_addr", wr_addr, m_dst);
            chk("R7", "remaining", remaining, m_cnt);
            if (rd_valid) begin
                chk("R2", "rd_seg", rd_seg, 3);
                chk("R2", "wr_seg", wr_seg, 0);
            end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (ready_rand) begin
            rd_ready = lfsr[0] | lfsr[5];
            wr_ready = lfsr[3] | lfsr[9];
        end else begin
            rd_ready = 1'b1;
            wr_ready = 1'b1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_state != 0) @(negedge clk);
    endtask

    task automatic launch(input int s, input int d, input int c,
                          input bit dn, input bit w);
        @(negedge clk);
        src_init = s[15:0]; dst_init = d[15:0]; count_init = c[15:0];
        dir_down = dn; elem_word = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic int end_ptr(input int p, input int c, input bit dn, input bit w);
        int st;
        st = (w ? 2 : 1) * c;
        return dn ? (p - st) & 16'hFFFF : (p + st) & 16'hFFFF;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "wr_valid", wr_valid, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "rd_addr", rd_addr, 0);
        chk("R1", "remaining", remaining, 0);
        run_cmp = 1;

        // R2/R4/R5: ascending bytes, ports always ready
        tag = "R4";
        launch(16'h1000, 16'h2000, 3, 0, 0);
        chk("R2", "rd_addr after load", rd_addr, 16'h1000);
        chk("R2", "wr_addr after load", wr_addr, 16'h2000);
        wait_idle();
        chk("R5", "byte end src", rd_addr, end_ptr(16'h1000, 3, 0, 0));
        chk("R5", "byte end dst", wr_addr, end_ptr(16'h2000, 3, 0, 0));

        // R3/R4/R5: descending words under random ready
        tag = "R3";
        ready_rand = 1;
        launch(16'h8000, 16'h9000, 6, 1, 1);
        wait_idle();
        chk("R5", "word down end src", rd_addr, end_ptr(16'h8000, 6, 1, 1));
        chk("R4", "word down end dst", wr_addr, end_ptr(16'h9000, 6, 1, 1));
        ready_rand = 0;

        // R6: wrap both ways
        tag = "R6";
        launch(16'hFFFF, 16'h0001, 3, 0, 1);
        wait_idle();
        chk("R6", "wrap up src", rd_addr, 16'h0005);
        launch(16'h0001, 16'hFFFE, 2, 1, 1);
        wait_idle();
        chk("R6", "wrap down src", rd_addr, 16'hFFFD);
        chk("R6", "dst", wr_addr, 16'hFFFA);

        // R8: zero count
        tag = "R8";
        launch(16'h4444, 16'h5555, 0, 0, 0);
        chk("R8", "done after zero start", done, 1);
        chk("R8", "no request", rd_valid, 0);
        @(negedge clk);
        chk("R8", "done single", done, 0);

        // R9: start pulses while busy
        tag = "R9";
        ready_rand = 1;
        launch(16'h0300, 16'h0600, 5, 0, 1);
        repeat (2) @(negedge clk);
        src_init = 16'hDEAD; dst_init = 16'hBEEF; count_init = 16'h0077; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_state != 2) @(negedge clk);
        start = 1'b1;  // during the done cycle
        @(negedge clk);
        start = 1'b0;
        chk("R9", "not reloaded", busy, 0);
        chk("R9", "end src", rd_addr, end_ptr(16'h0300, 5, 0, 1));
        ready_rand = 0;
        wait_idle();

        repeat (3) @(negedge clk);
        run_cmp = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule